// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding with Load-Use Stall

This block sits in the execute stage of a five-stage 16-bit pipeline and picks the value each source operand should use. Each source operand has its own selector. A selector compares the 3-bit source register number with the destination numbers of the instructions now in the memory and writeback stages. It then passes on one of four values: the register-file read value, the memory-stage ALU/address result, the writeback data, or the current program counter. Register 7 is the program counter, so a read of register 7 always returns the current PC.

A producer in the memory stage counts only when its bubble flag is clear and its register write enable is set. If that producer is a load, its data does not exist yet. The selector then asks for a stall instead of forwarding. The stall requests of the three operands are ORed into one stall.

While the stall is active, every earlier pipeline register and the PC keep their contents. A bubble is also injected into the execute-to-memory register. On the next cycle the load has moved to writeback and the held instruction is evaluated again, this time taking the loaded value from writeback. The block is purely combinational.

Top module: `exec_fwd_unit`

## Requirements
- R1: When the source register number is 7, the operand is `pc_cur`, whatever the memory and writeback stages hold, and that operand requests no stall.
- R2: A memory-stage producer matches when `mem_nop` is 0, `mem_dst` equals the source number and `mem_wen` is 1. On a match where `mem_is_load` is 0, the operand is `mem_alu`.
- R3: On a memory-stage match where `mem_is_load` is 1, the operand requests a stall. Its output then carries the operand's own register-file value, and the writeback stage is not consulted.
- R4: When there is no memory-stage match, a writeback producer with `wb_nop` 0, `wb_dst` equal to the source and `wb_wen` 1 makes the operand `wb_data`.
- R5: When both stages match the same source, the memory stage wins.
- R6: When nothing matches, the operand equals its register-file value. A producer with its bubble flag at 1, or with its write enable at 0, is ignored.
- R7: `stall` is 1 exactly when at least one of the three operands requests a stall.
- R8: `upstream_we` is the inverse of `stall`, and `em_bubble` equals `stall`.
- R9: Once the load has moved from memory to writeback with the same destination, the operand that stalled receives `wb_data` and the stall drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_reg | input | 9 | Source register numbers; operand i uses bits [3i+2:3i] |
| rf_data | input | 48 | Register-file read values; operand i uses bits [16i+15:16i] |
| pc_cur | input | 16 | Current program counter value |
| mem_nop | input | 1 | Memory stage bubble flag (1 = bubble) |
| mem_dst | input | 3 | Memory stage destination register |
| mem_wen | input | 1 | Memory stage register write enable |
| mem_is_load | input | 1 | Memory stage instruction is a load |
| mem_alu | input | 16 | Memory stage ALU/address result |
| wb_nop | input | 1 | Writeback stage bubble flag (1 = bubble) |
| wb_dst | input | 3 | Writeback stage destination register |
| wb_wen | input | 1 | Writeback stage register write enable |
| wb_data | input | 16 | Writeback stage result |
| opnd | output | 48 | Selected operands, same layout as rf_data |
| stall | output | 1 | Load-use stall |
| upstream_we | output | 1 | Write enable for earlier pipeline registers and PC |
| em_bubble | output | 1 | Sets the bubble flag of the execute-to-memory register |

## Verification
The bench uses the default parameters: 16-bit data, 3-bit register numbers and three operands. With only eight register numbers, random destinations hit a given source about one time in eight. Random vectors therefore produce memory matches, writeback matches, double matches and stalls on several operands together, without any biasing. Register 7 also turns up often enough in random traffic to test the PC override against a load that targets register 7.

// File: rtl/exec_fwd_pkg.sv
package exec_fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_MEM = 2'd1,
    SRC_WB  = 2'd2,
    SRC_PC  = 2'd3
  } fwd_src_e;
endpackage

// File: rtl/exec_fwd_sel.sv
module exec_fwd_sel
  import exec_fwd_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic [RW-1:0] src,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] pc_cur,
  input  logic          mem_nop,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_is_load,
  input  logic [DW-1:0] mem_alu,
  input  logic          wb_nop,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wen,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] opnd,
  output logic          stall_req
);
  localparam logic [RW-1:0] PC_REG = {RW{1'b1}};

  fwd_src_e sel;
  logic     mem_hit;
  logic     wb_hit;

  always_comb begin
    mem_hit = !mem_nop && (mem_dst == src) && mem_wen;
    wb_hit  = !wb_nop  && (wb_dst  == src) && wb_wen;
  end

  // priority: PC, then memory stage, then writeback
  always_comb begin
    sel       = SRC_RF;
    stall_req = 1'b0;
    if (src == PC_REG) begin
      sel = SRC_PC;
    end else if (mem_hit) begin
      if (mem_is_load) stall_req = 1'b1;
      else             sel = SRC_MEM;
    end else if (wb_hit) begin
      sel = SRC_WB;
    end
  end

  always_comb begin
    unique case (sel)
      SRC_PC:  opnd = pc_cur;
      SRC_MEM: opnd = mem_alu;
      SRC_WB:  opnd = wb_data;
      default: opnd = rf_val;
    endcase
  end

  always_comb begin
    if (src == PC_REG) begin
      p_pc_override_r1: assert (opnd == pc_cur && !stall_req);
    end
    if (stall_req) begin
      p_stall_needs_load_r3: assert (mem_is_load && mem_wen && !mem_nop && opnd == rf_val);
    end
    if (src != PC_REG && !mem_hit && !wb_hit) begin
      p_passthrough_r6: assert (opnd == rf_val && !stall_req);
    end
  end
endmodule

// File: rtl/exec_stall_gen.sv
module exec_stall_gen #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] req,
  output logic            stall,
  output logic            upstream_we,
  output logic            em_bubble
);
  always_comb begin
    stall       = |req;
    upstream_we = !stall;
    em_bubble   = stall;
  end

  always_comb begin
    p_hold_vs_bubble_r8: assert (upstream_we != em_bubble);
  end
endmodule

// File: rtl/exec_fwd_unit.sv
module exec_fwd_unit #(
  parameter int DW   = 16,
  parameter int RW   = 3,
  parameter int NSRC = 3
) (
  input  logic [NSRC*RW-1:0] src_reg,
  input  logic [NSRC*DW-1:0] rf_data,
  input  logic [DW-1:0]      pc_cur,
  input  logic               mem_nop,
  input  logic [RW-1:0]      mem_dst,
  input  logic               mem_wen,
  input  logic               mem_is_load,
  input  logic [DW-1:0]      mem_alu,
  input  logic               wb_nop,
  input  logic [RW-1:0]      wb_dst,
  input  logic               wb_wen,
  input  logic [DW-1:0]      wb_data,
  output logic [NSRC*DW-1:0] opnd,
  output logic               stall,
  output logic               upstream_we,
  output logic               em_bubble
);
  logic [NSRC-1:0] req;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    exec_fwd_sel #(.DW(DW), .RW(RW)) i_sel (
      .src         (src_reg[g*RW +: RW]),
      .rf_val      (rf_data[g*DW +: DW]),
      .pc_cur      (pc_cur),
      .mem_nop     (mem_nop),
      .mem_dst     (mem_dst),
      .mem_wen     (mem_wen),
      .mem_is_load (mem_is_load),
      .mem_alu     (mem_alu),
      .wb_nop      (wb_nop),
      .wb_dst      (wb_dst),
      .wb_wen      (wb_wen),
      .wb_data     (wb_data),
      .opnd        (opnd[g*DW +: DW]),
      .stall_req   (req[g])
    );
  end

  always_comb begin
    if (stall) begin
      p_stall_source_r7: assert (mem_is_load && mem_wen && !mem_nop);
    end
  end

  exec_stall_gen #(.NSRC(NSRC)) i_stall (
    .req         (req),
    .stall       (stall),
    .upstream_we (upstream_we),
    .em_bubble   (em_bubble)
  );
endmodule

// File: tb/test_exec_fwd_unit.sv
module test_exec_fwd_unit;
  localparam int DW = 16;
  localparam int RW = 3;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [NS*RW-1:0] src_reg;
  logic [NS*DW-1:0] rf_data;
  logic [DW-1:0]    pc_cur, mem_alu, wb_data;
  logic             mem_nop, mem_wen, mem_is_load, wb_nop, wb_wen;
  logic [RW-1:0]    mem_dst, wb_dst;
  logic [NS*DW-1:0] opnd;
  logic             stall, upstream_we, em_bubble;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  exec_fwd_unit i_exec_fwd_unit (.*);

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] exp_op(input int i);
    logic [RW-1:0] s;
    s = src_reg[i*RW +: RW];
    if (s == 3'd7) return pc_cur;
    if (!mem_nop && mem_dst == s && mem_wen) return mem_is_load ? rf_data[i*DW +: DW] : mem_alu;
    if (!wb_nop && wb_dst == s && wb_wen) return wb_data;
    return rf_data[i*DW +: DW];
  endfunction

  function automatic logic exp_stall();
    logic r = 1'b0;
    for (int i = 0; i < NS; i++) begin
      logic [RW-1:0] s;
      s = src_reg[i*RW +: RW];
      if (s != 3'd7 && !mem_nop && mem_dst == s && mem_wen && mem_is_load) r = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    @(negedge clk);
    #1;
    for (int i = 0; i < NS; i++) chk({tag, " R2 R4 R5 R6 opnd"}, opnd[i*DW +: DW], exp_op(i));
    chk({tag, " R7 stall"}, {15'd0, stall}, {15'd0, exp_stall()});
    chk({tag, " R8 upstream_we"}, {15'd0, upstream_we}, {15'd0, !exp_stall()});
    chk({tag, " R8 em_bubble"}, {15'd0, em_bubble}, {15'd0, exp_stall()});
  endtask

  task automatic quiet();
    mem_nop = 1'b1; mem_wen = 1'b0; mem_is_load = 1'b0; mem_dst = '0; mem_alu = 16'hAAAA;
    wb_nop  = 1'b1; wb_wen  = 1'b0; wb_dst = '0; wb_data = 16'hBBBB;
    pc_cur  = 16'h0100;
    rf_data = {16'h3333, 16'h2222, 16'h1111};
    src_reg = {3'd3, 3'd2, 3'd1};
  endtask

  initial begin
    quiet();
    void'($urandom(32'd1234));
    check_all("idle R6");
    chk("R6 op0 idle", opnd[15:0], 16'h1111);

    // R1: source 7 with matching load in memory stage
    src_reg = {3'd3, 3'd2, 3'd7};
    mem_nop = 0; mem_wen = 1; mem_is_load = 1; mem_dst = 3'd7;
    check_all("R1");
    chk("R1 pc", opnd[15:0], 16'h0100);
    chk("R1 no stall", {15'd0, stall}, 16'd0);

    // R2: non-load mem match on op1
    quiet(); mem_nop = 0; mem_wen = 1; mem_dst = 3'd2;
    check_all("R2");
    chk("R2 mem_alu", opnd[31:16], 16'hAAAA);

    // R5: both stages match
    wb_nop = 0; wb_wen = 1; wb_dst = 3'd2;
    check_all("R5");
    chk("R5 mem wins", opnd[31:16], 16'hAAAA);

    // R4: only writeback matches
    mem_dst = 3'd5;
    check_all("R4");
    chk("R4 wb", opnd[31:16], 16'hBBBB);

    // R6: disqualified producers ignored
    quiet(); mem_nop = 1; mem_wen = 1; mem_dst = 3'd1; wb_nop = 0; wb_wen = 0; wb_dst = 3'd1;
    check_all("R6");
    chk("R6 ignored", opnd[15:0], 16'h1111);

    // R3 then R9: load-use and recompute
    quiet(); mem_nop = 0; mem_wen = 1; mem_is_load = 1; mem_dst = 3'd3;
    wb_nop = 0; wb_wen = 1; wb_dst = 3'd3;
    check_all("R3");
    chk("R3 stall", {15'd0, stall}, 16'd1);
    chk("R3 rf value", opnd[47:32], 16'h3333);
    mem_nop = 1; mem_wen = 0; mem_is_load = 0; wb_data = 16'hC0DE;
    check_all("R9");
    chk("R9 loaded value", opnd[47:32], 16'hC0DE);
    chk("R9 stall drops", {15'd0, stall}, 16'd0);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      src_reg = NS*RW'($urandom);
      rf_data = {16'($urandom), 16'($urandom), 16'($urandom)};
      pc_cur = 16'($urandom); mem_alu = 16'($urandom); wb_data = 16'($urandom);
      mem_nop = ($urandom % 4) == 0; mem_wen = ($urandom % 4) != 0;
      mem_is_load = $urandom % 2; mem_dst = RW'($urandom);
      wb_nop = ($urandom % 4) == 0; wb_wen = ($urandom % 4) != 0; wb_dst = RW'($urandom);
      check_all("rand");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule